// File: doc/BRIEF.md
# Registered Arithmetic Logic Shift Unit

This block is a single-cycle datapath stage. It takes two N-bit operands, a 4-bit operation select and a carry-in, and forms a result from one of three groups: arithmetic, bitwise logic and single-position shift. On a clock edge where the load enable is high, it captures that result, the adder carry-out and a zero flag into output registers. When the load enable is low, those registers keep their values.

All arithmetic results come from one adder. A four-way multiplexer picks the adder's second input: the operand B, its complement, all zeros or all ones. The carry-in is then added. Add, add-with-carry, subtract-with-borrow, subtract, transfer, increment and decrement all fall out of this one structure. The upper two select bits pick the group and the lower two pick the operation within it.

Top module: `alsu_reg`

## Requirements
- R1: With sel[3:2]=00 and sel[1:0]=00 or 01, the loaded result is (A + Y + cin) mod 2^N. Y is B for sel[1:0]=00 and the bitwise complement of B for sel[1:0]=01.
- R2: With sel[3:2]=00, sel[1:0]=10 adds zero and sel[1:0]=11 adds all ones, each plus cin. This gives A (10, cin=0), A+1 (10, cin=1), A-1 (11, cin=0) and A again with carry-out 1 (11, cin=1).
- R3: With sel[3:2]=01, the result is A AND B for sel[1:0]=00, A OR B for 01, A XOR B for 10 and NOT A for 11. cin has no effect.
- R4: With sel[3:2]=10, the result is A shifted right by one position with 0 entering the MSB. sel[1:0] and cin have no effect.
- R5: With sel[3:2]=11, the result is A shifted left by one position with 0 entering the LSB. sel[1:0] and cin have no effect.
- R6: The registered carry-out is bit N of the adder sum when sel[3:2]=00, and 0 for every other group.
- R7: The registered zero flag is 1 exactly when the result loaded with it equals 0.
- R8: On an edge where ld_en is 0, the result, carry-out and zero flag keep their previous values.
- R9: A synchronous active-high rst clears the result, carry-out and zero flag, and takes priority over ld_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load enable for the output registers |
| a_in | input | N | Operand A |
| b_in | input | N | Operand B |
| sel | input | 4 | Operation select: [3:2] group, [1:0] operation |
| cin | input | 1 | Carry-in to the adder |
| f_q | output | N | Registered result |
| cout_q | output | 1 | Registered carry-out |
| zero_q | output | 1 | Registered zero flag |

## Verification
Reset and load can fall in the same cycle. The bench provokes this by raising rst together with ld_en while the operands select an addition whose result is nonzero. It then expects all three registers to read zero at the next sample. Load and hold also meet: the bench loads a known value and then changes the operands and select with ld_en low. It judges the outputs unchanged over those cycles. Every select, operand pair and carry-in is swept on a 4-bit configuration and compared against arithmetic done in the bench.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_SHR   = 2'b10,
    GRP_SHL   = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NOTB = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;

  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } lop_e;
endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
  import alsu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [1:0]   op,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         co
);
  localparam int W = N + 1;

  function automatic logic [N-1:0] pick_y(input logic [N-1:0] bv, input logic [1:0] s);
    case (ysel_e'(s))
      YSEL_B:    return bv;
      YSEL_NOTB: return ~bv;
      YSEL_ZERO: return '0;
      default:   return '1;
    endcase
  endfunction

  function automatic logic [W-1:0] add3(input logic [N-1:0] x, input logic [N-1:0] y,
                                        input logic c);
    return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
  endfunction

  logic [N-1:0] y_mux;
  logic [W-1:0] wide;

  assign y_mux = pick_y(b, op);
  assign wide  = add3(a, y_mux, cin);
  assign sum   = wide[N-1:0];
  assign co    = wide[N];

  // R2
  always_comb begin
    if (op == 2'b10 && cin == 1'b0) begin
      transfer_chk: assert (sum == a && co == 1'b0);
    end
  end
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
  import alsu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [1:0]   op,
  output logic [N-1:0] res
);
  function automatic logic bit_op(input logic x, input logic y, input logic [1:0] s);
    case (lop_e'(s))
      LOP_AND: return x & y;
      LOP_OR:  return x | y;
      LOP_XOR: return x ^ y;
      default: return ~x;
    endcase
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign res[i] = bit_op(a[i], b[i], op);
  end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  output logic [N-1:0] shr,
  output logic [N-1:0] shl
);
  for (genvar i = 0; i < N; i++) begin : g_pos
    if (i == N - 1) begin : g_top
      assign shr[i] = 1'b0;
    end else begin : g_r
      assign shr[i] = a[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl[i] = 1'b0;
    end else begin : g_l
      assign shl[i] = a[i-1];
    end
  end

  // R4
  always_comb begin
    shr_fill_chk: assert (shr[N-2:0] == a[N-1:1]);
  end
endmodule

// File: rtl/alsu_reg.sv
module alsu_reg
  import alsu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic [3:0]   sel,
  input  logic         cin,
  output logic [N-1:0] f_q,
  output logic         cout_q,
  output logic         zero_q
);
  grp_e         grp;
  logic [N-1:0] arith_res;
  logic         arith_co;
  logic [N-1:0] logic_res;
  logic [N-1:0] shr_res;
  logic [N-1:0] shl_res;
  logic [N-1:0] f_next;
  logic         co_next;
  logic         load_fire;

  assign grp       = grp_e'(sel[3:2]);
  assign load_fire = ld_en & ~rst;

  alsu_arith #(.N(N)) u_arith (
    .a(a_in), .b(b_in), .op(sel[1:0]), .cin(cin), .sum(arith_res), .co(arith_co)
  );
  alsu_logic #(.N(N)) u_logic (
    .a(a_in), .b(b_in), .op(sel[1:0]), .res(logic_res)
  );
  alsu_shift #(.N(N)) u_shift (
    .a(a_in), .shr(shr_res), .shl(shl_res)
  );

  always_comb begin
    co_next = 1'b0;
    case (grp)
      GRP_ARITH: begin f_next = arith_res; co_next = arith_co; end
      GRP_LOGIC: f_next = logic_res;
      GRP_SHR:   f_next = shr_res;
      default:   f_next = shl_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q    <= '0;
      cout_q <= 1'b0;
      zero_q <= 1'b0;
    end else if (ld_en) begin
      f_q    <= f_next;
      cout_q <= co_next;
      zero_q <= (f_next == '0);
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> ($stable(f_q) && $stable(cout_q) && $stable(zero_q)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (f_q == '0 && !cout_q && !zero_q));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    load_fire |=> (zero_q == (f_q == '0)));

  // R6
  carry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (load_fire && sel[3:2] != 2'b00) |=> !cout_q);

  // R3
  not_a_chk: assert property (@(posedge clk) disable iff (rst)
    (load_fire && sel == 4'b0111) |=> (f_q == ~$past(a_in)));
endmodule

// File: tb/alsu_reg_tb.sv
`timescale 1ns/1ps
module alsu_reg_tb;
  localparam int N    = 4;
  localparam int MASK = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst, ld_en, cin;
  logic [N-1:0] a_in, b_in;
  logic [3:0]   sel;
  logic [N-1:0] f_q;
  logic         cout_q, zero_q;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alsu_reg #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .a_in(a_in), .b_in(b_in),
    .sel(sel), .cin(cin), .f_q(f_q), .cout_q(cout_q), .zero_q(zero_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int s, input int a, input int b, input int c,
                                output int f, output int co);
    int y, t;
    co = 0;
    case (s >> 2)
      0: begin
        case (s & 3)
          0: y = b;
          1: y = MASK - b;
          2: y = 0;
          default: y = MASK;
        endcase
        t  = a + y + c;
        f  = t % (MASK + 1);
        co = t / (MASK + 1);
      end
      1: begin
        case (s & 3)
          0: f = a & b;
          1: f = a | b;
          2: f = a ^ b;
          default: f = MASK - a;
        endcase
      end
      2: f = a / 2;
      default: f = (a * 2) % (MASK + 1);
    endcase
  endfunction

  task automatic drive(input bit r, input bit ld, input int s, input int a,
                       input int b, input int c);
    rst = r; ld_en = ld; sel = 4'(s); a_in = N'(a); b_in = N'(b); cin = c[0];
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int ef, ec;
    string tf;
    rst = 1'b1; ld_en = 1'b0; sel = '0; a_in = '0; b_in = '0; cin = 1'b0;
    @(negedge clk);
    drive(1, 0, 0, 0, 0, 0);
    // R9 reset state
    chk("R9 f", int'(f_q), 0);
    chk("R9 cout", int'(cout_q), 0);
    chk("R9 zero", int'(zero_q), 0);

    // exhaustive sweep: R1 R2 R3 R4 R5 R6 R7
    for (int s = 0; s < 16; s++) begin
      for (int a = 0; a <= MASK; a++) begin
        for (int b = 0; b <= MASK; b++) begin
          for (int c = 0; c < 2; c++) begin
            drive(0, 1, s, a, b, c);
            model(s, a, b, c, ef, ec);
            case (s >> 2)
              0: tf = ((s & 3) < 2) ? "R1" : "R2";
              1: tf = "R3";
              2: tf = "R4";
              default: tf = "R5";
            endcase
            chk(tf, int'(f_q), ef);
            chk("R6", int'(cout_q), ec);
            chk("R7", int'(zero_q), (ef == 0) ? 1 : 0);
          end
        end
      end
    end

    // R2 wrap: A + all ones + 1 gives A with carry
    drive(0, 1, 3, 9, 0, 1);
    chk("R2 wrap f", int'(f_q), 9);
    chk("R2 wrap cout", int'(cout_q), 1);

    // R8 hold: load then change everything with ld_en low
    drive(0, 1, 0, 7, 9, 1);
    chk("R8 load f", int'(f_q), 1);
    chk("R8 load cout", int'(cout_q), 1);
    for (int k = 0; k < 4; k++) begin
      drive(0, 0, 4 + k * 3, k + 2, 15 - k, k & 1);
      chk("R8 hold f", int'(f_q), 1);
      chk("R8 hold cout", int'(cout_q), 1);
      chk("R8 hold zero", int'(zero_q), 0);
    end

    // R9 reset wins over load
    drive(0, 1, 0, 3, 4, 0);
    chk("R9 pre f", int'(f_q), 7);
    drive(1, 1, 0, 5, 6, 1);
    chk("R9 prio f", int'(f_q), 0);
    chk("R9 prio cout", int'(cout_q), 0);
    chk("R9 prio zero", int'(zero_q), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule